// File: doc/BRIEF.md
# PCI-X Target Split Response Controller

This block sits behind the target side of a PCI-X interface and decides how each incoming read is answered. A read is either finished on the spot, with its data handed back while the request is still on the bus, or it is answered with a split response. In that case the data is delivered later by a split completion that the initiator side of the interface sends. The block tracks how long the internal register file takes to produce the data. A read whose data does not come back within a sixteen-clock budget turns into a split. Reads of a configurable set of slow register offsets go to the split path at once, without waiting out the budget.

There is a single completion register, so only one split read can be outstanding. While a read is being decided, or a split is waiting for its data or for its completion to go out, every further read is told to retry. Posted writes and inbound split completions are never blocked and are acknowledged in every state. The completion register keeps the requester attributes, the address, the byte count and the data. It is released only when the initiator side reports that the completion has been sent.

Top module: `pcix_split_ctl`

## Requirements
- R1: A read (command 4'h6 memory read or 4'h2 I/O read) presented in the idle state, whose low 12 address bits are not in the slow table, is answered with a one-cycle `imm_valid` pulse carrying `rd_data`. This happens when `rd_data_ready` is high on one of the 16 rising edges that follow the request edge. The pulse appears one cycle after that edge and no split response is given.
- R2: If `rd_data_ready` stays low on all 16 of those edges, `split_rsp` pulses one cycle after the 16th edge. Readiness seen on the 16th edge still counts as immediate.
- R3: A read whose low 12 address bits match an entry of the slow table gets `split_rsp` one cycle after the request edge, with no wait. The default table holds the offsets 0x000, 0x004, 0x010, 0x018, 0x0C0, 0x0C4, 0x0C8, 0x0CC and 0x400.
- R4: After a split response, the first `rd_data_ready` captures `rd_data`. From the next cycle `cpl_req` is high, and `cpl_attr`, `cpl_addr`, `cpl_bcnt` and `cpl_data` carry the read's attributes, address, byte count and data.
- R5: `cpl_req` and the completion fields hold steady until `cpl_sent`. One cycle after `cpl_sent`, `cpl_req` is low and a new read is accepted.
- R6: A read presented while the block is not idle gets a one-cycle `retry` pulse one cycle later. It leaves the completion fields unchanged and produces neither `imm_valid` nor `split_rsp`.
- R7: A memory write (4'h7), an I/O write (4'h3) or an inbound split completion (4'hC) gets a one-cycle `wr_accept` pulse one cycle later in every state, and never a `retry`.
- R8: While `rst` is high at a clock edge, all pulse outputs and `cpl_req` are low after that edge.
- R9: `imm_valid` and `split_rsp` are never high together. Each accepted read receives exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decoded bus request present this cycle |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | AW (32) | Request address |
| req_attr | input | ATTR_W (16) | Requester attributes (tag, bus, device, function) |
| req_bcnt | input | BC_W (12) | Requested byte count |
| rd_data_ready | input | 1 | Register file has read data available |
| rd_data | input | DW (32) | Register file read data |
| cpl_sent | input | 1 | Initiator side has sent the split completion |
| reg_rd_en | output | 1 | Register read in progress |
| reg_rd_addr | output | AW (32) | Address of the register read in progress |
| imm_valid | output | 1 | Immediate read data pulse |
| imm_data | output | DW (32) | Immediate read data |
| split_rsp | output | 1 | Split response pulse |
| retry | output | 1 | Retry pulse for a read that cannot be taken |
| wr_accept | output | 1 | Posted write or split completion accepted |
| cpl_req | output | 1 | Split completion ready for the initiator side |
| cpl_attr | output | ATTR_W (16) | Stored requester attributes |
| cpl_addr | output | AW (32) | Stored address |
| cpl_bcnt | output | BC_W (12) | Stored byte count |
| cpl_data | output | DW (32) | Stored read data |

## Verification
The hardest case to reach from the ports is the exact boundary of the sixteen-clock budget. Data arriving on the 16th edge must still be returned immediately, and data one edge later must already have caused a split. The bench uses a single read task that counts edges from the request and raises `rd_data_ready` on a chosen edge. It runs that task at latencies 16 and 17 and checks the cycle in which each response appears. A completion register held busy is the other case that is hard to reach. To get there, the bench issues a slow-offset read and withholds `cpl_sent`. It then injects reads, writes and inbound split completions in that window.

// File: rtl/pcix_split_pkg.sv
package pcix_split_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_DATA  = 2'd1,
    ST_SPLIT_PEND = 2'd2,
    ST_SEND_CPL   = 2'd3
  } split_state_e;

  localparam logic [3:0] CMD_IO_RD     = 4'h2;
  localparam logic [3:0] CMD_IO_WR     = 4'h3;
  localparam logic [3:0] CMD_MEM_RD    = 4'h6;
  localparam logic [3:0] CMD_MEM_WR    = 4'h7;
  localparam logic [3:0] CMD_SPLIT_CPL = 4'hC;

  function automatic logic cmd_is_read(logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_MEM_RD);
  endfunction

  function automatic logic cmd_is_posted(logic [3:0] cmd);
    return (cmd == CMD_IO_WR) || (cmd == CMD_MEM_WR) || (cmd == CMD_SPLIT_CPL);
  endfunction

endpackage

// File: rtl/pcix_slow_match.sv
module pcix_slow_match #(
  parameter int OFF_W  = 12,
  parameter int N_SLOW = 9,
  parameter logic [N_SLOW*OFF_W-1:0] SLOW_TABLE = '0
) (
  input  logic [OFF_W-1:0] offset,
  output logic             hit
);
  logic [N_SLOW-1:0] hit_vec;

  for (genvar i = 0; i < N_SLOW; i++) begin : g_entry
    assign hit_vec[i] = (offset == SLOW_TABLE[i*OFF_W +: OFF_W]);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/pcix_wait_timer.sv
module pcix_wait_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // high on the edge that closes the budget window
  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/pcix_cpl_store.sv
module pcix_cpl_store #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int ATTR_W = 16,
  parameter int BC_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_hdr,
  input  logic [ATTR_W-1:0] hdr_attr,
  input  logic [AW-1:0]     hdr_addr,
  input  logic [BC_W-1:0]   hdr_bcnt,
  input  logic              load_data,
  input  logic [DW-1:0]     data_in,
  input  logic              clear,
  output logic              full,
  output logic [ATTR_W-1:0] q_attr,
  output logic [AW-1:0]     q_addr,
  output logic [BC_W-1:0]   q_bcnt,
  output logic [DW-1:0]     q_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      q_attr <= '0;
      q_addr <= '0;
      q_bcnt <= '0;
      q_data <= '0;
    end else begin
      if (load_hdr) begin
        q_attr <= hdr_attr;
        q_addr <= hdr_addr;
        q_bcnt <= hdr_bcnt;
      end
      if (load_data) begin
        q_data <= data_in;
        full   <= 1'b1;
      end else if (clear) begin
        full   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcix_split_ctl.sv
module pcix_split_ctl
  import pcix_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int ATTR_W     = 16,
  parameter int BC_W       = 12,
  parameter int OFF_W      = 12,
  parameter int WAIT_LIMIT = 16,
  parameter int N_SLOW     = 9,
  parameter logic [N_SLOW*OFF_W-1:0] SLOW_TABLE = {
    12'h400, 12'h0CC, 12'h0C8, 12'h0C4, 12'h0C0,
    12'h018, 12'h010, 12'h004, 12'h000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [AW-1:0]     req_addr,
  input  logic [ATTR_W-1:0] req_attr,
  input  logic [BC_W-1:0]   req_bcnt,
  input  logic              rd_data_ready,
  input  logic [DW-1:0]     rd_data,
  input  logic              cpl_sent,
  output logic              reg_rd_en,
  output logic [AW-1:0]     reg_rd_addr,
  output logic              imm_valid,
  output logic [DW-1:0]     imm_data,
  output logic              split_rsp,
  output logic              retry,
  output logic              wr_accept,
  output logic              cpl_req,
  output logic [ATTR_W-1:0] cpl_attr,
  output logic [AW-1:0]     cpl_addr,
  output logic [BC_W-1:0]   cpl_bcnt,
  output logic [DW-1:0]     cpl_data
);
  split_state_e      state;
  logic [ATTR_W-1:0] cur_attr;
  logic [AW-1:0]     cur_addr;
  logic [BC_W-1:0]   cur_bcnt;

  logic rd_req, wr_req, slow_hit, tmr_expired;
  logic in_idle, take_read;
  logic st_load_hdr, st_load_data, st_clear;
  logic [ATTR_W-1:0] hdr_attr;
  logic [AW-1:0]     hdr_addr;
  logic [BC_W-1:0]   hdr_bcnt;

  assign rd_req    = req_valid && cmd_is_read(req_cmd);
  assign wr_req    = req_valid && cmd_is_posted(req_cmd);
  assign in_idle   = (state == ST_IDLE);
  assign take_read = in_idle && rd_req;

  pcix_slow_match #(
    .OFF_W(OFF_W), .N_SLOW(N_SLOW), .SLOW_TABLE(SLOW_TABLE)
  ) u_match (
    .offset (req_addr[OFF_W-1:0]),
    .hit    (slow_hit)
  );

  pcix_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (take_read && !slow_hit),
    .run     (state == ST_WAIT_DATA),
    .expired (tmr_expired)
  );

  // header comes from the bus on a slow hit, from the held request on timeout
  assign st_load_hdr  = (take_read && slow_hit) ||
                        (state == ST_WAIT_DATA && !rd_data_ready && tmr_expired);
  assign hdr_attr     = in_idle ? req_attr : cur_attr;
  assign hdr_addr     = in_idle ? req_addr : cur_addr;
  assign hdr_bcnt     = in_idle ? req_bcnt : cur_bcnt;
  assign st_load_data = (state == ST_SPLIT_PEND) && rd_data_ready;
  assign st_clear     = (state == ST_SEND_CPL) && cpl_sent;

  pcix_cpl_store #(
    .AW(AW), .DW(DW), .ATTR_W(ATTR_W), .BC_W(BC_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .load_hdr  (st_load_hdr),
    .hdr_attr  (hdr_attr),
    .hdr_addr  (hdr_addr),
    .hdr_bcnt  (hdr_bcnt),
    .load_data (st_load_data),
    .data_in   (rd_data),
    .clear     (st_clear),
    .full      (cpl_req),
    .q_attr    (cpl_attr),
    .q_addr    (cpl_addr),
    .q_bcnt    (cpl_bcnt),
    .q_data    (cpl_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_attr  <= '0;
      cur_addr  <= '0;
      cur_bcnt  <= '0;
      imm_valid <= 1'b0;
      imm_data  <= '0;
      split_rsp <= 1'b0;
      retry     <= 1'b0;
      wr_accept <= 1'b0;
    end else begin
      imm_valid <= 1'b0;
      split_rsp <= 1'b0;
      // busy states turn every read away; posted traffic always passes
      retry     <= rd_req && !in_idle;
      wr_accept <= wr_req;

      unique case (state)
        ST_IDLE: begin
          if (rd_req) begin
            cur_attr <= req_attr;
            cur_addr <= req_addr;
            cur_bcnt <= req_bcnt;
            if (slow_hit) begin
              split_rsp <= 1'b1;
              state     <= ST_SPLIT_PEND;
            end else begin
              state     <= ST_WAIT_DATA;
            end
          end
        end
        ST_WAIT_DATA: begin
          if (rd_data_ready) begin
            imm_valid <= 1'b1;
            imm_data  <= rd_data;
            state     <= ST_IDLE;
          end else if (tmr_expired) begin
            split_rsp <= 1'b1;
            state     <= ST_SPLIT_PEND;
          end
        end
        ST_SPLIT_PEND: begin
          if (rd_data_ready) state <= ST_SEND_CPL;
        end
        ST_SEND_CPL: begin
          if (cpl_sent) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reg_rd_en   = (state == ST_WAIT_DATA) || (state == ST_SPLIT_PEND);
  assign reg_rd_addr = cur_addr;

endmodule

// File: rtl/pcix_split_ctl_chk.sv
module pcix_split_ctl_chk
  import pcix_split_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [3:0]    req_cmd,
  input logic          cpl_sent,
  input logic          imm_valid,
  input logic          split_rsp,
  input logic          retry,
  input logic          wr_accept,
  input logic          cpl_req,
  input logic [AW-1:0] cpl_addr,
  input logic [DW-1:0] cpl_data
);
  // R9
  split_imm_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(split_rsp && imm_valid));

  // R7
  posted_accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && cmd_is_posted(req_cmd) |=> wr_accept && !retry);

  // R6
  busy_retry_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && cmd_is_read(req_cmd) && cpl_req |=> retry);

  // R5
  cpl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_req && !cpl_sent |=> cpl_req && $stable(cpl_addr) && $stable(cpl_data));

  // R5
  cpl_release_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_req && cpl_sent |=> !cpl_req);
endmodule

bind pcix_split_ctl pcix_split_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .cpl_sent  (cpl_sent),
  .imm_valid (imm_valid),
  .split_rsp (split_rsp),
  .retry     (retry),
  .wr_accept (wr_accept),
  .cpl_req   (cpl_req),
  .cpl_addr  (cpl_addr),
  .cpl_data  (cpl_data)
);

// File: tb/pcix_split_ctl_bench.sv
module pcix_split_ctl_bench;
  localparam int AW = 32, DW = 32, ATTR_W = 16, BC_W = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [3:0]        req_cmd;
  logic [AW-1:0]     req_addr;
  logic [ATTR_W-1:0] req_attr;
  logic [BC_W-1:0]   req_bcnt;
  logic              rd_data_ready;
  logic [DW-1:0]     rd_data;
  logic              cpl_sent;
  logic              reg_rd_en;
  logic [AW-1:0]     reg_rd_addr;
  logic              imm_valid;
  logic [DW-1:0]     imm_data;
  logic              split_rsp;
  logic              retry;
  logic              wr_accept;
  logic              cpl_req;
  logic [ATTR_W-1:0] cpl_attr;
  logic [AW-1:0]     cpl_addr;
  logic [BC_W-1:0]   cpl_bcnt;
  logic [DW-1:0]     cpl_data;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  pcix_split_ctl u_pcix_split_ctl (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    req_valid = 0; req_cmd = 4'h0; req_addr = '0; req_attr = '0; req_bcnt = '0;
  endtask

  task automatic drive_req(input logic [3:0] c, input logic [AW-1:0] a,
                           input logic [ATTR_W-1:0] at, input logic [BC_W-1:0] bc);
    req_valid = 1; req_cmd = c; req_addr = a; req_attr = at; req_bcnt = bc;
  endtask

  // one read, data ready raised on edge k after the request edge
  task automatic do_read(input logic [3:0] c, input logic [AW-1:0] a,
                         input logic [ATTR_W-1:0] at, input logic [BC_W-1:0] bc,
                         input int k, input logic [DW-1:0] d,
                         output int imm_at, output logic [DW-1:0] imm_d,
                         output int split_at);
    imm_at = 0; split_at = 0; imm_d = '0;
    @(negedge clk);
    drive_req(c, a, at, bc);
    for (int i = 1; i <= k + 2; i++) begin
      @(negedge clk);
      idle_bus();
      if (imm_valid) begin imm_at = i; imm_d = imm_data; end
      if (split_rsp) split_at = i;
      rd_data_ready = (i == k);
      rd_data       = (i == k) ? d : '0;
    end
    rd_data_ready = 0;
  endtask

  task automatic send_cpl();
    cpl_sent = 1;
    @(negedge clk);
    cpl_sent = 0;
  endtask

  task automatic t_reset();
    rst = 1; idle_bus(); rd_data_ready = 0; rd_data = '0; cpl_sent = 0;
    repeat (3) @(negedge clk);
    chk(!imm_valid && !split_rsp && !retry && !wr_accept, "R8 pulses low in reset",
        {imm_valid, split_rsp, retry, wr_accept}, 0);
    chk(!cpl_req, "R8 cpl_req low in reset", cpl_req, 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_fast();
    int ia, sa; logic [DW-1:0] id;
    do_read(4'h6, 32'h1000_0100, 16'h0101, 12'd4, 3, 32'hA5A5_0003, ia, id, sa);
    chk(ia == 4, "R1 fast mem read imm cycle", ia, 4);
    chk(id == 32'hA5A5_0003, "R1 fast mem read data", id, 32'hA5A5_0003);
    chk(sa == 0, "R9 no split on fast read", sa, 0);
    do_read(4'h2, 32'h0000_0204, 16'h0202, 12'd4, 1, 32'h1234_5678, ia, id, sa);
    chk(ia == 2 && id == 32'h1234_5678, "R1 io read ready on first edge", id, 32'h1234_5678);
  endtask

  task automatic t_edge();
    int ia, sa; logic [DW-1:0] id;
    do_read(4'h6, 32'h2000_0300, 16'h0303, 12'd8, 16, 32'hBEEF_0016, ia, id, sa);
    chk(ia == 17, "R2 ready on 16th edge still immediate", ia, 17);
    chk(sa == 0, "R2 no split at boundary", sa, 0);
    do_read(4'h6, 32'h2000_0340, 16'h0C0D, 12'd12, 17, 32'hBEEF_0017, ia, id, sa);
    chk(sa == 17, "R2 split after 16th edge", sa, 17);
    chk(ia == 0, "R9 no imm on timed-out read", ia, 0);
    chk(cpl_req, "R4 cpl_req after data", cpl_req, 1);
    chk(cpl_data == 32'hBEEF_0017, "R4 cpl_data", cpl_data, 32'hBEEF_0017);
    chk(cpl_addr == 32'h2000_0340, "R4 cpl_addr", cpl_addr, 32'h2000_0340);
    chk(cpl_attr == 16'h0C0D && cpl_bcnt == 12'd12, "R4 cpl attr/bcnt",
        {cpl_attr, cpl_bcnt}, {16'h0C0D, 12'd12});
    send_cpl();
    chk(!cpl_req, "R5 cpl_req cleared after cpl_sent", cpl_req, 0);
  endtask

  task automatic t_slow_busy();
    int ia, sa; logic [DW-1:0] id;
    do_read(4'h6, 32'h4000_00C4, 16'h0A0B, 12'd4, 5, 32'hC0DE_00C4, ia, id, sa);
    chk(sa == 1, "R3 slow offset splits at once", sa, 1);
    chk(ia == 0, "R3 slow read no imm", ia, 0);
    chk(cpl_req && cpl_data == 32'hC0DE_00C4, "R4 slow read completion data",
        cpl_data, 32'hC0DE_00C4);
    // R6 read while completion pending
    drive_req(4'h2, 32'h4000_0500, 16'h7777, 12'd4);
    @(negedge clk); idle_bus();
    chk(retry, "R6 read retried while busy", retry, 1);
    chk(cpl_addr == 32'h4000_00C4 && cpl_attr == 16'h0A0B, "R6 completion untouched",
        cpl_addr, 32'h4000_00C4);
    @(negedge clk);
    chk(!imm_valid && !split_rsp, "R6 retried read gets no answer",
        {imm_valid, split_rsp}, 0);
    // R7 write and split completion pass while busy
    drive_req(4'h7, 32'h4000_0600, 16'h1111, 12'd4);
    @(negedge clk); idle_bus();
    chk(wr_accept && !retry, "R7 mem write accepted while busy", {wr_accept, retry}, 2'b10);
    drive_req(4'hC, 32'h4000_0700, 16'h2222, 12'd4);
    @(negedge clk); idle_bus();
    chk(wr_accept && !retry, "R7 split completion accepted while busy",
        {wr_accept, retry}, 2'b10);
    repeat (4) @(negedge clk);
    chk(cpl_req && cpl_data == 32'hC0DE_00C4, "R5 completion held without ack",
        cpl_data, 32'hC0DE_00C4);
    send_cpl();
    chk(!cpl_req, "R5 released by cpl_sent", cpl_req, 0);
    do_read(4'h6, 32'h4000_0800, 16'h3333, 12'd4, 2, 32'h0000_0800, ia, id, sa);
    chk(ia == 3 && id == 32'h0000_0800, "R5 new read accepted after release", ia, 3);
  endtask

  task automatic t_wait_retry();
    @(negedge clk);
    drive_req(4'h6, 32'h5000_0100, 16'h4444, 12'd4);
    @(negedge clk);
    drive_req(4'h6, 32'h5000_0200, 16'h5555, 12'd4);
    @(negedge clk);
    idle_bus();
    chk(retry, "R6 read retried during wait", retry, 1);
    rd_data_ready = 1; rd_data = 32'h5000_0100;
    @(negedge clk);
    rd_data_ready = 0;
    chk(imm_valid && imm_data == 32'h5000_0100, "R1 first read unaffected by retried one",
        imm_data, 32'h5000_0100);
    drive_req(4'h3, 32'h5000_0300, 16'h6666, 12'd4);
    @(negedge clk); idle_bus();
    chk(wr_accept, "R7 io write accepted when idle", wr_accept, 1);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fast();
    t_edge();
    t_slow_busy();
    t_wait_retry();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule